// File: doc/BRIEF.md
# SAR ADC Sequencer

This block is the digital control of an 8-bit successive-approximation analog-to-digital converter. A CPU sees it as two 8-bit registers picked by a single register-select pin: a mode/status register and a read-only result register. One write to the mode register sets an input channel, a comparator bias choice and a start command. The sequencer then runs a binary search over the code space. It presents one trial code per step to an external DAC and comparator, and keeps or drops the trial bit according to the comparator's answer.

Each conversion has eight steps of 21 clocks, which is 168 clocks in total. When the search ends, the final code is copied into the result register and a done flag rises in the mode register. After a start, the done flag keeps its old value for a fixed delay of up to 16 clocks and then clears. The channel and bias outputs are captured when a start is accepted and stay frozen until the next start.

There is no streaming data path. Register access is a plain one-cycle write strobe with a combinational read, and it has no back-pressure. The comparator input is sampled with no handshake.

Top module: `sar_adc_seq`

## Requirements
- R1: The conversion decides one bit per step, from bit 7 down to bit 0. The first trial code is 0x80. A comparator answer of 1 (input at or above `dac_code`) keeps the trial bit, and each later trial sets the next lower bit. With a monotonic comparator the result equals the input level, including 0x00 and 0xFF.
- R2: The result register (`reg_sel`=1) is read-only. Writes to it leave both the result and the mode register unchanged, whether they come during a conversion or after it.
- R3: Mode register layout: bits 6:4 hold the channel, bit 3 is start, bit 2 is the done flag and bit 1 is bias. Bits 7 and 0 read 0. The channel and bias fields read back as last written, and a write to bit 2 has no effect.
- R4: Start self-clears. Bit 3 reads 1 only in the cycle after the write that set it and reads 0 from then on.
- R5: The done flag goes to 1, and the result becomes readable, exactly 168 clock edges after the edge that accepted the start. At edge 167 the flag still reads 0.
- R6: After a start, the done flag keeps its previous value through edge 15 and reads 0 from edge 16 onward.
- R7: The comparator is sampled on the last clock of each 21-clock step. `dac_code` is 0x80 from the start edge, and the first decision lands at edge 20. Later decisions land every 21 edges (41, 62, …, 167).
- R8: A single write can carry channel, bias and start together. `ch_sel` and `bias_sel` take the written values at the start edge.
- R9: Rewriting the mode fields without start during a conversion does not change `ch_sel` or `bias_sel`, and does not disturb the search. The new fields appear in the readback.
- R10: A start during a running conversion restarts the search from bit 7. The old conversion produces no result and no done flag. The new result arrives 168 edges after the restart.
- R11: With no start, the done flag, the result and `dac_code` stay constant indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the result register |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| dac_code | output | 8 | Trial code driven to the external DAC |
| cmp_in | input | 1 | Comparator answer: 1 when the input is at or above the DAC level |
| ch_sel | output | 3 | Channel select captured at start |
| bias_sel | output | 1 | Comparator bias select captured at start |

## Verification
Each result has a fixed edge, counted from the edge that accepts a start. The start bit reads back at edge 0 and is clear at edge 1. The first trial code and the captured selects are visible at edge 0. Trial codes change at edges 20, 41 and every 21 edges after that. The done flag clears at edge 16, and the result and done flag are due at edge 168. The bench counts rising edges and samples at the falling edge after the target edge. It checks both sides of each boundary (edges 15/16, 19/20 and 167/168), so an off-by-one in any counter is caught.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Mode register field positions (software-visible layout)
  localparam int CH_LSB    = 4;
  localparam int CH_W      = 3;
  localparam int START_BIT = 3;
  localparam int EOC_BIT   = 2;
  localparam int BIAS_BIT  = 1;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic            bias;
  } sel_t;
endpackage

// File: rtl/sar_mode_regs.sv
module sar_mode_regs
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              eoc_clr,
  output logic              start_req,
  output logic              start_q,
  output logic              eoc_q,
  output logic [DATA_W-1:0] mode_rd
);
  logic mode_wr;
  sel_t sw_sel;

  assign mode_wr   = wr_en && !reg_sel;
  assign start_req = mode_wr && wr_data[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_sel  <= '0;
      start_q <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      if (mode_wr) begin
        sw_sel.ch   <= wr_data[CH_LSB +: CH_W];
        sw_sel.bias <= wr_data[BIAS_BIT];
      end
      start_q <= start_req;
      if (commit)       eoc_q <= 1'b1;
      else if (eoc_clr) eoc_q <= 1'b0;
    end
  end

  always_comb begin
    mode_rd                    = '0;
    mode_rd[CH_LSB +: CH_W]    = sw_sel.ch;
    mode_rd[START_BIT]         = start_q;
    mode_rd[EOC_BIT]           = eoc_q;
    mode_rd[BIAS_BIT]          = sw_sel.bias;
  end
endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int BITS      = 8,
  parameter int STEP_CLKS = 21,
  parameter int EOC_DELAY = 16   // 2..16, must be below BITS*STEP_CLKS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_req,
  output logic                        busy,
  output logic                        decide,
  output logic                        commit,
  output logic [$clog2(BITS)-1:0]     bit_idx,
  output logic                        eoc_clr
);
  localparam int TW  = $clog2(STEP_CLKS);
  localparam int IW  = $clog2(BITS);
  localparam int DLW = $clog2(EOC_DELAY + 1);

  logic [TW-1:0]  tick;
  logic [DLW-1:0] dly;
  logic           pend;

  assign decide  = busy && (tick == TW'(STEP_CLKS - 1));
  assign commit  = pend;
  assign eoc_clr = (dly == DLW'(1)) && !start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tick    <= '0;
      bit_idx <= '0;
      pend    <= 1'b0;
      dly     <= '0;
    end else if (start_req) begin
      // the start cycle counts as the first clock of the MSB step
      busy    <= 1'b1;
      tick    <= TW'(1);
      bit_idx <= IW'(BITS - 1);
      pend    <= 1'b0;
      dly     <= DLW'(EOC_DELAY);
    end else begin
      pend <= 1'b0;
      if (dly != '0) dly <= dly - DLW'(1);
      if (busy) begin
        if (decide) begin
          tick <= '0;
          if (bit_idx == '0) begin
            busy <= 1'b0;
            pend <= 1'b1;
          end else begin
            bit_idx <= bit_idx - IW'(1);
          end
        end else begin
          tick <= tick + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int BITS = 8,
  parameter int IW   = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            decide,
  input  logic            commit,
  input  logic [IW-1:0]   bit_idx,
  input  logic            cmp_in,
  output logic [BITS-1:0] code,
  output logic [BITS-1:0] result
);
  logic [BITS-1:0] next_code;

  // Per bit: the bit under test takes the comparator answer,
  // the bit just below it becomes the next trial bit.
  for (genvar g = 0; g < BITS; g++) begin : g_bit
    if (g == BITS - 1) begin : g_top
      assign next_code[g] = (bit_idx == IW'(g)) ? cmp_in : code[g];
    end else begin : g_low
      assign next_code[g] = (bit_idx == IW'(g))     ? cmp_in :
                            (bit_idx == IW'(g + 1)) ? 1'b1   : code[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code <= '0;
    else if (start_req) code <= {1'b1, {(BITS-1){1'b0}}};
    else if (decide)    code <= next_code;
  end

  // Result has no defined reset value.
  always_ff @(posedge clk) begin
    if (commit) result <= code;
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STEP_CLKS = 21,
  parameter int EOC_DELAY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dac_code,
  input  logic              cmp_in,
  output logic [CH_W-1:0]   ch_sel,
  output logic              bias_sel
);
  localparam int IW = $clog2(DATA_W);

  logic              start_req, start_q, eoc_q, commit, eoc_clr;
  logic              busy, decide;
  logic [IW-1:0]     bit_idx;
  logic [DATA_W-1:0] mode_rd, result;
  sel_t              sel_lat;

  sar_mode_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .commit(commit), .eoc_clr(eoc_clr),
    .start_req(start_req), .start_q(start_q), .eoc_q(eoc_q),
    .mode_rd(mode_rd)
  );

  sar_step_timer #(.BITS(DATA_W), .STEP_CLKS(STEP_CLKS), .EOC_DELAY(EOC_DELAY)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy(busy),
    .decide(decide), .commit(commit), .bit_idx(bit_idx), .eoc_clr(eoc_clr)
  );

  sar_search #(.BITS(DATA_W), .IW(IW)) u_search (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .decide(decide),
    .commit(commit), .bit_idx(bit_idx), .cmp_in(cmp_in),
    .code(dac_code), .result(result)
  );

  // Selects are captured from the start write itself and frozen until the next start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lat <= '0;
    end else if (start_req) begin
      sel_lat.ch   <= wr_data[CH_LSB +: CH_W];
      sel_lat.bias <= wr_data[BIAS_BIT];
    end
  end

  assign ch_sel   = sel_lat.ch;
  assign bias_sel = sel_lat.bias;
  assign rd_data  = reg_sel ? result : mode_rd;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              reg_sel,
  input logic              start_req,
  input logic              start_q,
  input logic              commit,
  input logic              busy,
  input logic              eoc_q,
  input logic [DATA_W-1:0] result,
  input logic [2:0]        ch_sel,
  input logic              bias_sel
);
  // R2: a write to the result register never alters it
  a_r2_result_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && !commit) |=> $stable(result));

  // R4: start reads back for one cycle only unless re-written
  a_r4_start_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> (!start_q || $past(start_req)));

  // R5: done flag follows the result load
  a_r5_eoc_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> eoc_q);

  // R5: done flag rises only through a result load
  a_r5_eoc_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_q) |-> $past(commit));

  // R6: done flag is not touched at the start edge
  a_r6_eoc_holds_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (eoc_q == $past(eoc_q)));

  // R9: captured selects do not move while converting
  a_r9_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_req) |=> ($stable(ch_sel) && $stable(bias_sel)));

  // R10: a start cancels any pending result load
  a_r10_restart_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !commit);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
  .start_req(start_req), .start_q(start_q), .commit(commit), .busy(busy),
  .eoc_q(eoc_q), .result(result), .ch_sel(ch_sel), .bias_sel(bias_sel)
);

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, dac_code;
  logic       cmp_in, bias_sel;
  logic [2:0] ch_sel;
  logic [7:0] vin [8];
  int         vectors = 0, miscompares = 0, edge_cnt = 0, t0 = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // comparator model: 1 when the selected input is at or above the DAC level
  assign cmp_in = (vin[ch_sel] >= dac_code);

  sar_adc_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .dac_code(dac_code),
    .cmp_in(cmp_in), .ch_sel(ch_sel), .bias_sel(bias_sel)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h (edge %0d)", tag, got, exp, edge_cnt);
    end
  endtask

  function automatic logic [7:0] mode_word(input int ch, input bit st, input bit b);
    return {1'b0, 3'(ch), st, 1'b0, b, 1'b0};
  endfunction

  // trial code after j decisions for input v
  function automatic logic [7:0] trial(input logic [7:0] v, input int j);
    logic [7:0] known;
    known = (j == 0) ? 8'h00 : (v & (8'hFF << (8 - j)));
    return (j < 8) ? (known | (8'h80 >> j)) : known;
  endfunction

  // one-cycle write; returns just after the accepting edge
  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic start(input int ch, input logic [7:0] v, input bit b);
    vin[ch] = v;
    wr(1'b0, mode_word(ch, 1'b1, b));
    t0 = edge_cnt;
  endtask

  task automatic at_edge(input int n);
    while (edge_cnt < n) @(negedge clk);
  endtask

  task automatic rd(input bit sel, output logic [7:0] d);
    reg_sel = sel; #0.5; d = rd_data;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    at_edge(2);
    rd(1'b0, d); chk(d, 8'h00, "R3 reset mode register");
    chk(dac_code, 8'h00, "R11 reset dac_code");
    chk({4'h0, ch_sel, bias_sel}, 8'h00, "R8 reset selects");
  endtask

  task automatic t_convert(input int ch, input logic [7:0] v, input bit b);
    logic [7:0] d;
    start(ch, v, b);
    at_edge(t0);
    rd(1'b0, d);
    chk(d[3], 1'b1, "R4 start reads 1 after write");
    chk({5'h0, ch_sel}, 8'(ch), "R8 channel captured");
    chk({7'h0, bias_sel}, {7'h0, b}, "R8 bias captured");
    chk(dac_code, 8'h80, "R1 first trial");
    at_edge(t0 + 1); rd(1'b0, d); chk(d[3], 1'b0, "R4 start self-cleared");
    at_edge(t0 + 19); chk(dac_code, trial(v, 0), "R7 no decision before edge 20");
    at_edge(t0 + 20); chk(dac_code, trial(v, 1), "R7 MSB decided at edge 20");
    at_edge(t0 + 41); chk(dac_code, trial(v, 2), "R7 second decision at edge 41");
    at_edge(t0 + 167); rd(1'b0, d); chk(d[2], 1'b0, "R5 done still low at edge 167");
    at_edge(t0 + 168);
    rd(1'b0, d);
    chk(d[2], 1'b1, "R5 done at edge 168");
    chk(d, mode_word(ch, 1'b0, b) | 8'h04, "R3 mode readback layout");
    rd(1'b1, d); chk(d, v, "R1 result equals input");
  endtask

  task automatic t_eoc_delay();
    logic [7:0] d;
    start(2, 8'h3C, 1'b0);
    at_edge(t0 + 15); rd(1'b0, d); chk(d[2], 1'b1, "R6 done kept through edge 15");
    at_edge(t0 + 16); rd(1'b0, d); chk(d[2], 1'b0, "R6 done cleared at edge 16");
    at_edge(t0 + 168); rd(1'b1, d); chk(d, 8'h3C, "R1 result after delayed clear");
  endtask

  task automatic t_result_ro();
    logic [7:0] d, m;
    start(6, 8'h6D, 1'b1);
    at_edge(t0 + 60);
    wr(1'b1, 8'hFF);
    at_edge(t0 + 168);
    rd(1'b1, d); chk(d, 8'h6D, "R2 write during conversion ignored");
    rd(1'b0, m);
    wr(1'b1, 8'h00);
    at_edge(edge_cnt + 1);
    rd(1'b1, d); chk(d, 8'h6D, "R2 write after conversion ignored");
    rd(1'b0, d); chk(d, m, "R2 mode unchanged by result write");
  endtask

  task automatic t_rewrite_during();
    logic [7:0] d;
    vin[7] = 8'h11;
    start(1, 8'h5A, 1'b1);
    at_edge(t0 + 30);
    wr(1'b0, 8'h74);  // channel 7, done bit set, no start, bias 0
    at_edge(edge_cnt + 1);
    chk({5'h0, ch_sel}, 8'h01, "R9 channel held");
    chk({7'h0, bias_sel}, 8'h01, "R9 bias held");
    rd(1'b0, d); chk(d, 8'h70, "R3 R9 readback shows new fields, bit 2 not writable");
    at_edge(t0 + 167); rd(1'b0, d); chk(d[2], 1'b0, "R9 conversion not shortened");
    at_edge(t0 + 168); rd(1'b1, d); chk(d, 8'h5A, "R9 result from captured channel");
  endtask

  task automatic t_restart();
    logic [7:0] d;
    int t1;
    start(3, 8'h99, 1'b0);
    at_edge(t0 + 50);
    start(4, 8'h2E, 1'b1);
    t1 = t0;
    chk(dac_code, 8'h80, "R10 restart from MSB");
    at_edge(t1 + 120); rd(1'b0, d); chk(d[2], 1'b0, "R10 no done from abandoned run");
    at_edge(t1 + 167); rd(1'b0, d); chk(d[2], 1'b0, "R10 done low at edge 167");
    at_edge(t1 + 168);
    rd(1'b0, d); chk(d[2], 1'b1, "R10 done at edge 168 after restart");
    rd(1'b1, d); chk(d, 8'h2E, "R10 result of restarted run");
  endtask

  task automatic t_idle();
    logic [7:0] d, r, c;
    rd(1'b1, r); c = dac_code;
    at_edge(edge_cnt + 300);
    rd(1'b0, d); chk(d[2], 1'b1, "R11 done held while idle");
    rd(1'b1, d); chk(d, r, "R11 result held while idle");
    chk(dac_code, c, "R11 dac_code held while idle");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_convert(5, 8'hA7, 1'b1);
    t_convert(0, 8'h00, 1'b0);
    t_convert(7, 8'hFF, 1'b1);
    t_eoc_delay();
    t_result_ro();
    t_rewrite_during();
    t_restart();
    t_idle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule